// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 20-bit virtual page number into a 20-bit physical frame number for a 32-bit, two-level, 4 KB-page translation scheme. Optionally, 4 MB large pages are also supported. A requester presents the page number together with write and user flags while the walker is ready. The walker then fetches the directory entry, and the table entry if needed, over a single-outstanding word memory port. On the way it sets the accessed and dirty bits in memory and checks the user and writable rights. It finishes with a one-cycle done pulse that carries either a frame number with access rights or a fault code.

The table root frame, the paging enable, the supervisor write-protect enable, the large-page enable and a 32-bit address mask come from outside the block and must stay stable during a walk. The mask is applied to every table address and to the frame returned. The block has no translation storage of its own. A caller that later needs write permission on a page first granted without it simply walks again.

Entry bit positions: bit0 present, bit1 writable, bit2 user, bit5 accessed, bit6 dirty, bit7 large page, bits 31:12 frame. The result rights field uses bit0 for read, bit1 for write and bit2 for execute. The fault code uses bit0 for protection (1) or not present (0), bit1 for a write access and bit2 for a user access.

Top module: `vat_walker`

## Requirements
- R1: With paging disabled, the result is the request page number ANDed with mask bits 31:12, the rights are 3'b111, no fault is raised and no memory access is made.
- R2: The directory entry is read at ({root frame, 12'h0} + {vpn[19:10], 2'b00}) AND mask.
- R3: The table entry is read at ({directory entry[31:12], 12'h0} + {vpn[9:0], 2'b00}) AND mask. A directory entry with bit7 set while large pages are disabled is walked as a 4 KB mapping.
- R4: When the directory entry has bit7 set and large pages are enabled, no table entry is read. The frame is {entry[31:22], vpn[9:0]} AND mask bits 31:12.
- R5: For a 4 KB mapping the effective user and writable bits are the AND of both levels. A user access without user permission faults, and a user write without writable permission faults.
- R6: A supervisor write to a non-writable page faults only when write-protect is enabled.
- R7: When the leaf's accessed bit is clear, or a write finds its dirty bit clear, the leaf is written back with accessed set, and with dirty set as well for a write. On a 4 KB walk, a directory entry whose accessed bit is clear is written back with it set before the table entry is read.
- R8: Write rights are returned only when the leaf's dirty bit, after any write-back, is set and the access rules allow writing. Read and execute rights are always returned on success.
- R9: A not-present entry at either level gives fault code bit0=0, and a rights violation gives bit0=1. Bit1 is the write flag and bit2 is the user flag. On a fault the rights field is 0.
- R10: A request is taken only while ready is high. Done is high for exactly one cycle per request. A memory request holds its address, write enable and data until acknowledged.
- R11: Every table address and every returned frame passes through the address mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken while ready) |
| req_vpn | input | 20 | Virtual page number |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user privilege |
| ready | output | 1 | Walker idle and accepting a request |
| cfg_root_frame | input | 20 | Frame of the directory table |
| cfg_pg_en | input | 1 | Paging enable |
| cfg_wp | input | 1 | Supervisor write-protect enable |
| cfg_big_en | input | 1 | Large-page enable |
| cfg_a20_mask | input | 32 | Physical address mask |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Access complete (read data valid) |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 3 | Fault code (see R9) |
| res_pfn | output | 20 | Physical frame number |
| res_perm | output | 3 | Rights: bit0 read, bit1 write, bit2 execute |

## Verification
A wrong walk state is visible at the memory port within one access. A wrong address or a wrong write-back value lands in a different table word, and the next compare of the table memory exposes it. Mistakes in the rights logic or the dirty tracking show up in the rights field or the fault code on the very next done pulse. Lost accessed or dirty updates are caught after each walk, because the bench compares both table words it touched against a reference copy. Control errors show at the ports as a missing or stretched done pulse or a request that does not hold. Random tables with aliasing root, directory and table frames drive walks where a write-back changes the word read next.

// File: rtl/vat_pkg.sv
package vat_pkg;
  localparam int VA_W   = 32;
  localparam int PG_SH  = 12;
  localparam int VPN_W  = VA_W - PG_SH;
  localparam int IDX_W  = VPN_W / 2;
  localparam int BIT_P  = 0;
  localparam int BIT_RW = 1;
  localparam int BIT_US = 2;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;
  localparam int BIT_PS = 7;

  typedef logic [VA_W-1:0]  word_t;
  typedef logic [VPN_W-1:0] frame_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_WB_DIR, ST_RD_TBL, ST_WB_TBL, ST_FIN
  } walk_st_e;
endpackage

// File: rtl/vat_addr_gen.sv
module vat_addr_gen
  import vat_pkg::*;
(
  input  frame_t root_frame,
  input  frame_t dir_frame,
  input  frame_t vpn,
  input  word_t  mask,
  output word_t  dir_addr,
  output word_t  tbl_addr
);
  localparam int PAD_W = PG_SH - 2;

  word_t dir_off, tbl_off;

  assign dir_off  = {{(VA_W-PG_SH){1'b0}}, vpn[VPN_W-1 -: IDX_W], 2'b00};
  assign tbl_off  = {{(VA_W-PG_SH){1'b0}}, vpn[IDX_W-1:0], 2'b00};
  assign dir_addr = ({root_frame, {PAD_W{1'b0}}, 2'b00} + dir_off) & mask;
  assign tbl_addr = ({dir_frame,  {PAD_W{1'b0}}, 2'b00} + tbl_off) & mask;
endmodule

// File: rtl/vat_perm_chk.sv
module vat_perm_chk
  import vat_pkg::*;
(
  input  logic  dir_u,
  input  logic  dir_rw,
  input  word_t leaf,
  input  logic  big,
  input  logic  user,
  input  logic  write,
  input  logic  wp,
  output logic  viol,
  output logic  need_wb,
  output logic  grant_w,
  output word_t leaf_upd
);
  logic eff_u, eff_rw, rights_w;

  assign eff_u    = dir_u  & (big | leaf[BIT_US]);
  assign eff_rw   = dir_rw & (big | leaf[BIT_RW]);
  assign viol     = user ? (!eff_u || (write && !eff_rw))
                         : (write && wp && !eff_rw);
  assign rights_w = user ? eff_rw : (!wp || eff_rw);
  assign need_wb  = !leaf[BIT_A] || (write && !leaf[BIT_D]);

  always_comb begin
    leaf_upd        = leaf;
    leaf_upd[BIT_A] = 1'b1;
    if (write) leaf_upd[BIT_D] = 1'b1;
  end

  assign grant_w = rights_w & leaf_upd[BIT_D];
endmodule

// File: rtl/vat_walker.sv
module vat_walker
  import vat_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [19:0] req_vpn,
  input  logic        req_write,
  input  logic        req_user,
  output logic        ready,
  input  logic [19:0] cfg_root_frame,
  input  logic        cfg_pg_en,
  input  logic        cfg_wp,
  input  logic        cfg_big_en,
  input  logic [31:0] cfg_a20_mask,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic        fault,
  output logic [2:0]  fault_code,
  output logic [19:0] res_pfn,
  output logic [2:0]  res_perm
);
  walk_st_e st;
  frame_t   vpn_q, vpn_cur, pfn_ok;
  logic     wr_q, us_q, big_q, big_cur;
  word_t    pde_q, pte_q, pde_cur, pte_cur, leaf;
  word_t    dir_addr, tbl_addr, leaf_upd, pde_acc;
  logic     viol, need_wb, grant_w;

  // Current entries come straight from the read bus in the cycle they arrive.
  assign pde_cur = (st == ST_RD_DIR) ? mem_rdata : pde_q;
  assign pte_cur = (st == ST_RD_TBL) ? mem_rdata : pte_q;
  assign big_cur = (st == ST_RD_DIR) ? (mem_rdata[BIT_PS] & cfg_big_en) : big_q;
  assign vpn_cur = (st == ST_IDLE) ? req_vpn : vpn_q;
  assign leaf    = big_cur ? pde_cur : pte_cur;

  always_comb begin
    pde_acc        = pde_cur;
    pde_acc[BIT_A] = 1'b1;
  end

  vat_addr_gen u_addr (
    .root_frame (cfg_root_frame),
    .dir_frame  (pde_cur[VA_W-1:PG_SH]),
    .vpn        (vpn_cur),
    .mask       (cfg_a20_mask),
    .dir_addr   (dir_addr),
    .tbl_addr   (tbl_addr)
  );

  vat_perm_chk u_perm (
    .dir_u    (pde_cur[BIT_US]),
    .dir_rw   (pde_cur[BIT_RW]),
    .leaf     (leaf),
    .big      (big_cur),
    .user     (us_q),
    .write    (wr_q),
    .wp       (cfg_wp),
    .viol     (viol),
    .need_wb  (need_wb),
    .grant_w  (grant_w),
    .leaf_upd (leaf_upd)
  );

  assign pfn_ok = (big_cur ? {pde_cur[VA_W-1 -: IDX_W], vpn_q[IDX_W-1:0]}
                           : pte_cur[VA_W-1:PG_SH]) & cfg_a20_mask[VA_W-1:PG_SH];

  assign ready = (st == ST_IDLE);
  assign done  = (st == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      vpn_q <= '0; wr_q <= 1'b0; us_q <= 1'b0; big_q <= 1'b0;
      pde_q <= '0; pte_q <= '0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      fault <= 1'b0; fault_code <= '0; res_pfn <= '0; res_perm <= '0;
    end else begin
      if (mem_ack) mem_req <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          vpn_q <= req_vpn; wr_q <= req_write; us_q <= req_user;
          fault <= 1'b0; fault_code <= '0;
          if (!cfg_pg_en) begin
            res_pfn  <= req_vpn & cfg_a20_mask[VA_W-1:PG_SH];
            res_perm <= 3'b111;
            st       <= ST_FIN;
          end else begin
            mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= dir_addr;
            st      <= ST_RD_DIR;
          end
        end
        ST_RD_DIR: if (mem_ack) begin
          pde_q <= mem_rdata;
          big_q <= big_cur;
          if (!mem_rdata[BIT_P]) begin
            fault <= 1'b1; fault_code <= {us_q, wr_q, 1'b0};
            res_perm <= '0; res_pfn <= '0; st <= ST_FIN;
          end else if (big_cur && viol) begin
            fault <= 1'b1; fault_code <= {us_q, wr_q, 1'b1};
            res_perm <= '0; res_pfn <= '0; st <= ST_FIN;
          end else if (big_cur && need_wb) begin
            mem_req <= 1'b1; mem_we <= 1'b1; mem_wdata <= leaf_upd;
            st <= ST_WB_DIR;
          end else if (big_cur) begin
            res_pfn <= pfn_ok; res_perm <= {1'b1, grant_w, 1'b1}; st <= ST_FIN;
          end else if (!mem_rdata[BIT_A]) begin
            mem_req <= 1'b1; mem_we <= 1'b1; mem_wdata <= pde_acc;
            st <= ST_WB_DIR;
          end else begin
            mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= tbl_addr;
            st <= ST_RD_TBL;
          end
        end
        ST_WB_DIR: if (mem_ack) begin
          if (big_q) begin
            res_pfn <= pfn_ok; res_perm <= {1'b1, grant_w, 1'b1}; st <= ST_FIN;
          end else begin
            mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= tbl_addr;
            st <= ST_RD_TBL;
          end
        end
        ST_RD_TBL: if (mem_ack) begin
          pte_q <= mem_rdata;
          if (!mem_rdata[BIT_P] || viol) begin
            fault <= 1'b1; fault_code <= {us_q, wr_q, mem_rdata[BIT_P]};
            res_perm <= '0; res_pfn <= '0; st <= ST_FIN;
          end else if (need_wb) begin
            mem_req <= 1'b1; mem_we <= 1'b1; mem_wdata <= leaf_upd;
            st <= ST_WB_TBL;
          end else begin
            res_pfn <= pfn_ok; res_perm <= {1'b1, grant_w, 1'b1}; st <= ST_FIN;
          end
        end
        ST_WB_TBL: if (mem_ack) begin
          res_pfn <= pfn_ok; res_perm <= {1'b1, grant_w, 1'b1}; st <= ST_FIN;
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vat_walker_chk.sv
module vat_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        done,
  input logic        fault,
  input logic [2:0]  res_perm
);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !ready);

  a_r7_wb_marks_accessed: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata[5] && mem_wdata[0]));

  a_r9_fault_no_rights: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (res_perm == 3'b000));

  a_r8_success_readable: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (res_perm[0] && res_perm[2]));

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

bind vat_walker vat_walker_chk i_vat_walker_chk (
  .clk       (clk),
  .rst       (rst),
  .ready     (ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .done      (done),
  .fault     (fault),
  .res_perm  (res_perm)
);

// File: tb/test_vat_walker.sv
module test_vat_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EP  = 32'h1, ERW = 32'h2, EU = 32'h4;
  localparam logic [31:0] EA  = 32'h20, ED = 32'h40, EPS = 32'h80;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [19:0] req_vpn = '0;
  logic        ready;
  logic [19:0] cfg_root_frame = 20'h00010;
  logic        cfg_pg_en = 1'b1, cfg_wp = 1'b1, cfg_big_en = 1'b1;
  logic [31:0] cfg_a20_mask = 32'hFFFF_FFFF;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        done, fault;
  logic [2:0]  fault_code, res_perm;
  logic [19:0] res_pfn;

  int n_chk = 0, n_fail = 0, acc_cnt = 0;
  logic [31:0] dut_mem [logic [29:0]];
  logic [31:0] ref_mem [logic [29:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  vat_walker i_vat_walker (.*);

  function automatic logic [31:0] drd(logic [31:0] a);
    return dut_mem.exists(a[31:2]) ? dut_mem[a[31:2]] : 32'h0;
  endfunction
  function automatic logic [31:0] rrd(logic [31:0] a);
    return ref_mem.exists(a[31:2]) ? ref_mem[a[31:2]] : 32'h0;
  endfunction

  // Memory model: one-cycle registered acknowledge.
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      acc_cnt++;
      if (mem_we) dut_mem[mem_addr[31:2]] = mem_wdata;
      else mem_rdata <= drd(mem_addr);
    end else mem_ack <= 1'b0;
  end

  task automatic put(input logic [31:0] a, input logic [31:0] v);
    dut_mem[a[31:2]] = v;
    ref_mem[a[31:2]] = v;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dir_of(logic [19:0] vpn);
    return (({cfg_root_frame, 12'h0}) + {20'h0, vpn[19:10], 2'b00}) & cfg_a20_mask;
  endfunction
  function automatic logic [31:0] tbl_of(logic [31:0] pde, logic [19:0] vpn);
    return ({pde[31:12], 12'h0} + {20'h0, vpn[9:0], 2'b00}) & cfg_a20_mask;
  endfunction

  // Reference walk built from the requirements.
  task automatic ref_walk(input logic [19:0] vpn, input bit w, input bit u,
                          output bit f, output logic [2:0] code,
                          output logic [19:0] pfn, output logic [2:0] pm,
                          output logic [31:0] da, output logic [31:0] ta, output bit has_t);
    logic [31:0] pde, pte, leaf;
    bit big, eu, erw, rights;
    f = 0; code = 0; pfn = 0; pm = 0; has_t = 0; ta = 0;
    da = dir_of(vpn);
    if (!cfg_pg_en) begin                                  // R1
      pfn = vpn & cfg_a20_mask[31:12]; pm = 3'b111; return;
    end
    pde = rrd(da);                                         // R2
    if (!pde[0]) begin f = 1; code = {u, w, 1'b0}; return; end
    big = pde[7] && cfg_big_en;
    if (big) begin
      eu = pde[2]; erw = pde[1]; leaf = pde;                // R4
    end else begin
      if (!pde[5]) ref_mem[da[31:2]] = pde | EA;           // R7
      ta = tbl_of(pde, vpn); has_t = 1;                    // R3
      pte = rrd(ta);
      if (!pte[0]) begin f = 1; code = {u, w, 1'b0}; return; end
      eu = pde[2] & pte[2]; erw = pde[1] & pte[1]; leaf = pte;  // R5
    end
    if (u ? (!eu || (w && !erw)) : (w && cfg_wp && !erw)) begin  // R6
      f = 1; code = {u, w, 1'b1}; return;
    end
    if (!leaf[5] || (w && !leaf[6])) begin
      leaf = leaf | EA | (w ? ED : 32'h0);
      if (big) ref_mem[da[31:2]] = leaf; else ref_mem[ta[31:2]] = leaf;
    end
    rights = u ? erw : (!cfg_wp || erw);
    pm  = {1'b1, leaf[6] & rights, 1'b1};                  // R8
    pfn = (big ? {pde[31:22], vpn[9:0]} : leaf[31:12]) & cfg_a20_mask[31:12];  // R11
  endtask

  task automatic walk(input logic [19:0] vpn, input bit w, input bit u);
    bit ef, has_t;
    logic [2:0] ec, epm;
    logic [19:0] epfn;
    logic [31:0] da, ta;
    ref_walk(vpn, w, u, ef, ec, epfn, epm, da, ta, has_t);
    @(negedge clk);
    while (!ready) @(negedge clk);
    acc_cnt = 0;
    req_valid = 1'b1; req_vpn = vpn; req_write = w; req_user = u;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk("R9 fault flag", {31'h0, fault}, {31'h0, ef});
    if (ef) begin
      chk("R9 fault code", {29'h0, fault_code}, {29'h0, ec});
      chk("R9 no rights on fault", {29'h0, res_perm}, 32'h0);
    end else begin
      chk("R11 frame", {12'h0, res_pfn}, {12'h0, epfn});
      chk("R8 rights", {29'h0, res_perm}, {29'h0, epm});
    end
    if (!cfg_pg_en) chk("R1 no memory access", acc_cnt, 0);
    else begin
      chk("R7 directory word", drd(da), rrd(da));
      if (has_t) chk("R7 table word", drd(ta), rrd(ta));
    end
    @(negedge clk);
    chk("R10 done one cycle", {31'h0, done}, 32'h0);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk("R10 reset ready", {31'h0, ready}, 32'h1);
    chk("R10 reset done", {31'h0, done}, 32'h0);
    chk("R10 reset mem_req", {31'h0, mem_req}, 32'h0);

    // R1: paging off, mask clears address bit 20
    cfg_pg_en = 1'b0; cfg_a20_mask = 32'hFFEF_FFFF;
    walk(20'h00123, 1'b1, 1'b1);
    chk("R1 masked frame", {12'h0, res_pfn}, 32'h0000_0023);
    cfg_pg_en = 1'b1; cfg_a20_mask = 32'hFFFF_FFFF; cfg_root_frame = 20'h00010;

    // R9: directory entry not present, user write -> code 3'b110
    put(32'h0001_0004, 32'h0);
    walk({10'd1, 10'd1}, 1'b1, 1'b1);
    chk("R9 not-present code", {29'h0, fault_code}, 32'h6);

    // R7/R8: clean 4 KB page, user read -> read-only rights, A bits set
    put(32'h0001_0008, 32'h0002_0000 | EP | ERW | EU);
    put(32'h0002_000C, 32'hABCD_E000 | EP | ERW | EU);
    walk({10'd2, 10'd3}, 1'b0, 1'b1);
    chk("R8 clean page no write", {29'h0, res_perm}, 32'h5);
    chk("R7 pte accessed", drd(32'h0002_000C), 32'hABCD_E000 | EP | ERW | EU | EA);
    walk({10'd2, 10'd3}, 1'b1, 1'b1);
    chk("R8 first write grants", {29'h0, res_perm}, 32'h7);

    // R5/R6: read-only table entry
    put(32'h0002_0010, 32'h1234_5000 | EP | EU | EA | ED);
    walk({10'd2, 10'd4}, 1'b1, 1'b1);
    chk("R5 user write ro code", {29'h0, fault_code}, 32'h7);
    walk({10'd2, 10'd4}, 1'b1, 1'b0);
    chk("R6 sup write wp=1 code", {29'h0, fault_code}, 32'h3);
    cfg_wp = 1'b0;
    walk({10'd2, 10'd4}, 1'b1, 1'b0);
    chk("R6 sup write wp=0 ok", {31'h0, fault}, 32'h0);
    cfg_wp = 1'b1;

    // R4: large page, then the same entry with large pages disabled (R3)
    put(32'h0001_0014, 32'hC000_0000 | EPS | EP | ERW | EU | EA | ED);
    walk({10'd5, 10'h2AB}, 1'b0, 1'b1);
    chk("R4 large frame", {12'h0, res_pfn}, 32'h000C_02AB);
    chk("R4 no table read", acc_cnt, 1);
    cfg_big_en = 1'b0;
    walk({10'd5, 10'h2AB}, 1'b0, 1'b1);
    chk("R3 large bit ignored", {29'h0, fault_code}, 32'h4);
    cfg_big_en = 1'b1;

    // Random walks over aliasing tables
    for (int i = 0; i < 400; i++) begin
      logic [19:0] vpn;
      logic [31:0] pde, pte;
      cfg_root_frame = {16'h0, 4'($urandom_range(0, 3))};
      cfg_pg_en  = ($urandom_range(0, 15) != 0);
      cfg_wp     = 1'($urandom);
      cfg_big_en = 1'($urandom);
      cfg_a20_mask = ($urandom_range(0, 3) == 0) ? 32'hFFEF_FFFF : 32'hFFFF_FFFF;
      vpn = 20'($urandom);
      pde = {12'h0, 4'($urandom_range(0, 3)), 4'h0, 12'($urandom)};
      if ($urandom_range(0, 2) == 0) pde[31:22] = 10'($urandom);
      if ($urandom_range(0, 7) != 0) pde = pde | EP;
      pte = $urandom;
      if ($urandom_range(0, 7) != 0) pte = pte | EP;
      put(dir_of(vpn), pde);
      put(tbl_of(pde, vpn), pte);
      walk(vpn, 1'($urandom), 1'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule